// File: doc/BRIEF.md
# Configurable Serial Shift Interface

A byte-wide serial shift unit for a small processor. Software reaches it through a four-register port: the live shift register, a buffer that keeps the last completed byte, a status register, and a control register. Each shift moves the register one place to the left and takes the serial input into bit 0. Shifts come from one of four sources, selected in control: a software strobe, a pulse from an on-chip timer compare match, or the rising or falling edge of the serial clock pin.

A counter tracks clock events. When it wraps, it raises an overflow flag and copies the shift register into the buffer. The most significant bit drives the serial output through a latch. With an internal source the latch is always open. With an external clock it opens only in the half period in which the bit may change, so data is sampled on one edge and changes on the other. In the two-wire mode the unit watches for bus start and stop conditions and reports when its own output bit disagrees with the line. In the other modes any serial clock edge can raise the start flag, which serves as a wake-up cue.

Top module: `ssi_unit`

## Requirements
- R1: After reset every register reads zero and the serial output is 0.
- R2: Register map by `bus_addr`: 0 is the shift register, 1 is the buffer (read only), 2 is status, 3 is control. Control holds wire mode in bits 5:4 (0 none, 1 three-wire, 2 or 3 two-wire), clock source in bits 3:2, and counter-by-strobe in bit 1. Bit 0 is a strobe that reads back 0. `bus_rdata` shows the addressed register in the same cycle.
- R3: With source 0, writing control with bit 0 set shifts the register left once and takes `sdi_in` into bit 0. The shift uses the source in force before that write.
- R4: With source 1, each cycle in which `tmr_match` is high shifts once. A software strobe in this mode leaves the shift register unchanged.
- R5: Source 2 shifts on a rising edge of `sck_in` and source 3 on a falling edge. An edge is a change from the level sampled in the previous cycle.
- R6: When a write to the shift register falls in the same cycle as a shift, the register takes the written value and does not shift. The counter still advances.
- R7: Status bits 3:0 form a counter. With source 0 or 1 it advances once per shift. With an external source it advances on both clock edges, or on each software strobe when control bit 1 is set. A wrap from 15 to 0 sets the overflow flag, status bit 6. A status write loads the counter and takes precedence over a count event.
- R8: On each wrap the buffer takes the value the shift register holds after that cycle.
- R9: Status bits 7 (start), 6 (overflow) and 5 (stop) clear when a one is written to them. A set in the same cycle takes precedence over the clear.
- R10: With source 0 or 1, `sdo_out` follows bit 7 of the shift register at once. With source 2 it follows only while `sck_in` is low, and with source 3 only while it is high. Otherwise it holds its last value.
- R11: In two-wire mode, `sdi_in` falling while `sck_in` is high in both cycles sets the start flag, and `sdi_in` rising under the same condition sets the stop flag.
- R12: Outside two-wire mode, with an external source and control bit 1 clear, any `sck_in` edge sets the start flag. With control bit 1 set, edges do not set it.
- R13: Status bit 4 reads 1 only in two-wire mode when bit 7 of the shift register differs from `sdi_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed register |
| tmr_match | input | 1 | Timer compare-match pulse |
| sck_in | input | 1 | Serial clock pin, already synchronous |
| sdi_in | input | 1 | Serial data pin, already synchronous |
| sdo_out | output | 1 | Serial data output after the latch |

## Verification
A software write to the shift register and a shift from the timer or the serial clock can fall in the same cycle. So can a status write and a flag set or count event. The bench provokes both. It writes the data register while `tmr_match` is high, and it writes a clear to the start flag in the cycle in which a start condition appears on the pins. In each case it judges the outcome by reading back the register and the status counter and comparing them with a behavioural model. That model applies the rules that the write wins the data and the set wins the flag, while the counter still advances.

// File: rtl/ssi_pkg.sv
`timescale 1ns/1ps
package ssi_pkg;

   typedef enum logic [1:0] {
      SRC_SOFT     = 2'd0,
      SRC_TIMER    = 2'd1,
      SRC_EXT_RISE = 2'd2,
      SRC_EXT_FALL = 2'd3
   } clk_src_e;

   localparam logic [1:0] ADR_DATA = 2'd0;
   localparam logic [1:0] ADR_BUF  = 2'd1;
   localparam logic [1:0] ADR_STAT = 2'd2;
   localparam logic [1:0] ADR_CTRL = 2'd3;

   // flag vector positions (vector is placed at the top of status)
   localparam int NFLAG      = 3;
   localparam int FLAG_START = 2;
   localparam int FLAG_OVF   = 1;
   localparam int FLAG_STOP  = 0;

   typedef struct packed {
      logic [1:0] wmode;
      clk_src_e   src;
      logic       cnt_sw;
   } ctrl_t;

endpackage

// File: rtl/ssi_line_mon.sv
`timescale 1ns/1ps
module ssi_line_mon (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_in,
   input  logic sdi_in,
   output logic sck_rise,
   output logic sck_fall,
   output logic start_cond,
   output logic stop_cond
);
   logic sck_q;
   logic sdi_q;
   logic scl_high;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         sdi_q <= 1'b0;
      end else begin
         sck_q <= sck_in;
         sdi_q <= sdi_in;
      end
   end

   assign sck_rise   = sck_in & ~sck_q;
   assign sck_fall   = ~sck_in & sck_q;
   assign scl_high   = sck_in & sck_q;
   assign start_cond = scl_high & sdi_q & ~sdi_in;
   assign stop_cond  = scl_high & ~sdi_q & sdi_in;
endmodule

// File: rtl/ssi_clk_route.sv
`timescale 1ns/1ps
module ssi_clk_route
   import ssi_pkg::*;
(
   input  clk_src_e src,
   input  logic     cnt_sw,
   input  logic     sw_strobe,
   input  logic     tmr_match,
   input  logic     sck_in,
   input  logic     sck_rise,
   input  logic     sck_fall,
   output logic     shift_ev,
   output logic     cnt_ev,
   output logic     edge_start,
   output logic     latch_open
);
   logic any_edge;
   assign any_edge = sck_rise | sck_fall;

   always_comb begin
      shift_ev   = 1'b0;
      cnt_ev     = 1'b0;
      edge_start = 1'b0;
      latch_open = 1'b1;
      case (src)
         SRC_SOFT: begin
            shift_ev = sw_strobe;
            cnt_ev   = sw_strobe;
         end
         SRC_TIMER: begin
            shift_ev = tmr_match;
            cnt_ev   = tmr_match;
         end
         SRC_EXT_RISE: begin
            shift_ev   = sck_rise;
            latch_open = ~sck_in;
         end
         default: begin
            shift_ev   = sck_fall;
            latch_open = sck_in;
         end
      endcase
      if (src == SRC_EXT_RISE || src == SRC_EXT_FALL) begin
         cnt_ev     = cnt_sw ? sw_strobe : any_edge;
         edge_start = ~cnt_sw & any_edge;
      end
   end
endmodule

// File: rtl/ssi_shifter.sv
`timescale 1ns/1ps
module ssi_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              shift_ev,
   input  logic              sdi_in,
   input  logic              cap_en,
   input  logic              latch_open,
   output logic [DATA_W-1:0] sr_q,
   output logic [DATA_W-1:0] buf_q,
   output logic              sdo
);
   localparam int MSB = DATA_W - 1;

   if (DATA_W < 2) begin : g_width_check
      $error("ssi_shifter: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] sr_d;
   logic              lat_q;

   always_comb begin
      if (wr_en)         sr_d = wr_data;
      else if (shift_ev) sr_d = {sr_q[MSB-1:0], sdi_in};
      else               sr_d = sr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q  <= '0;
         buf_q <= '0;
         lat_q <= 1'b0;
      end else begin
         sr_q  <= sr_d;
         lat_q <= sdo;
         if (cap_en) buf_q <= sr_d;
      end
   end

   assign sdo = latch_open ? sr_q[MSB] : lat_q;
endmodule

// File: rtl/ssi_cnt_flags.sv
`timescale 1ns/1ps
module ssi_cnt_flags
   import ssi_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_ev,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic [NFLAG-1:0] ext_set,
   input  logic [NFLAG-1:0] flag_clr,
   output logic [CNT_W-1:0] cnt_q,
   output logic             ovf_ev,
   output logic [NFLAG-1:0] flags
);
   logic [NFLAG-1:0] set_vec;

   assign ovf_ev = cnt_ev & ~cnt_wr & (&cnt_q);

   always_comb begin
      set_vec           = ext_set;
      set_vec[FLAG_OVF] = ovf_ev;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_wr) cnt_q <= cnt_wdata;
      else if (cnt_ev) cnt_q <= cnt_q + 1'b1;
   end

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      logic f_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           f_q <= 1'b0;
         else if (set_vec[i])  f_q <= 1'b1;
         else if (flag_clr[i]) f_q <= 1'b0;
      end
      assign flags[i] = f_q;
   end
endmodule

// File: rtl/ssi_unit.sv
`timescale 1ns/1ps
module ssi_unit
   import ssi_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              tmr_match,
   input  logic              sck_in,
   input  logic              sdi_in,
   output logic              sdo_out
);
   localparam int MSB   = DATA_W - 1;
   localparam int PAD_W = DATA_W - NFLAG - 1 - CNT_W;

   if (DATA_W < 8) begin : g_dw_check
      $error("ssi_unit: DATA_W must be at least 8");
   end
   if (CNT_W < 1 || PAD_W < 0) begin : g_cw_check
      $error("ssi_unit: counter does not fit in status");
   end

   ctrl_t             ctrl_q;
   logic              data_wr, stat_wr, ctrl_wr, sw_strobe;
   logic              sck_rise, sck_fall, start_cond, stop_cond;
   logic              shift_ev, cnt_ev, edge_start, latch_open;
   logic              two_wire, dcoll, ovf_ev, flag_ovf;
   logic [1:0]        ctrl_src;
   logic [NFLAG-1:0]  flags, ext_set, flag_clr;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] shreg_q, buf_q, stat_word, ctrl_word;

   assign data_wr   = bus_wr & (bus_addr == ADR_DATA);
   assign stat_wr   = bus_wr & (bus_addr == ADR_STAT);
   assign ctrl_wr   = bus_wr & (bus_addr == ADR_CTRL);
   assign sw_strobe = ctrl_wr & bus_wdata[0];
   assign two_wire  = ctrl_q.wmode[1];
   assign ctrl_src  = ctrl_q.src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '{wmode: 2'b00, src: SRC_SOFT, cnt_sw: 1'b0};
      end else if (ctrl_wr) begin
         ctrl_q.wmode  <= bus_wdata[5:4];
         ctrl_q.src    <= clk_src_e'(bus_wdata[3:2]);
         ctrl_q.cnt_sw <= bus_wdata[1];
      end
   end

   ssi_line_mon u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .sck_in     (sck_in),
      .sdi_in     (sdi_in),
      .sck_rise   (sck_rise),
      .sck_fall   (sck_fall),
      .start_cond (start_cond),
      .stop_cond  (stop_cond)
   );

   ssi_clk_route u_route (
      .src        (ctrl_q.src),
      .cnt_sw     (ctrl_q.cnt_sw),
      .sw_strobe  (sw_strobe),
      .tmr_match  (tmr_match),
      .sck_in     (sck_in),
      .sck_rise   (sck_rise),
      .sck_fall   (sck_fall),
      .shift_ev   (shift_ev),
      .cnt_ev     (cnt_ev),
      .edge_start (edge_start),
      .latch_open (latch_open)
   );

   ssi_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (data_wr),
      .wr_data    (bus_wdata),
      .shift_ev   (shift_ev),
      .sdi_in     (sdi_in),
      .cap_en     (ovf_ev),
      .latch_open (latch_open),
      .sr_q       (shreg_q),
      .buf_q      (buf_q),
      .sdo        (sdo_out)
   );

   always_comb begin
      ext_set             = '0;
      ext_set[FLAG_START] = two_wire ? start_cond : edge_start;
      ext_set[FLAG_STOP]  = two_wire & stop_cond;
      flag_clr            = stat_wr ? bus_wdata[MSB -: NFLAG] : '0;
   end

   ssi_cnt_flags #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_ev    (cnt_ev),
      .cnt_wr    (stat_wr),
      .cnt_wdata (bus_wdata[CNT_W-1:0]),
      .ext_set   (ext_set),
      .flag_clr  (flag_clr),
      .cnt_q     (cnt_q),
      .ovf_ev    (ovf_ev),
      .flags     (flags)
   );

   assign flag_ovf = flags[FLAG_OVF];
   assign dcoll    = two_wire & (shreg_q[MSB] ^ sdi_in);

   if (PAD_W > 0) begin : g_pad
      assign stat_word = {flags, dcoll, {PAD_W{1'b0}}, cnt_q};
   end else begin : g_nopad
      assign stat_word = {flags, dcoll, cnt_q};
   end

   assign ctrl_word = {{(DATA_W-6){1'b0}}, ctrl_q.wmode, ctrl_q.src, ctrl_q.cnt_sw, 1'b0};

   always_comb begin
      case (bus_addr)
         ADR_DATA: bus_rdata = shreg_q;
         ADR_BUF:  bus_rdata = buf_q;
         ADR_STAT: bus_rdata = stat_word;
         default:  bus_rdata = ctrl_word;
      endcase
   end
endmodule

// File: rtl/ssi_unit_chk.sv
`timescale 1ns/1ps
module ssi_unit_chk #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              sck_in,
   input logic              sdi_in,
   input logic              sdo_out,
   input logic [DATA_W-1:0] shreg,
   input logic [DATA_W-1:0] bufreg,
   input logic [CNT_W-1:0]  cnt,
   input logic              flag_ovf,
   input logic              data_wr,
   input logic              stat_wr,
   input logic              shift_ev,
   input logic              cnt_ev,
   input logic              two_wire,
   input logic [1:0]        src
);
   localparam int MSB = DATA_W - 1;

   p_wr_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr |=> shreg == $past(bus_wdata));

   p_shift_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_ev && !data_wr) |=> shreg == {$past(shreg[MSB-1:0]), $past(sdi_in)});

   p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_ev && !stat_wr) |=> cnt == CNT_W'($past(cnt) + 1'b1));

   p_ovf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_ev && !stat_wr && (&cnt)) |=> flag_ovf);

   p_buf_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_ev && !stat_wr && (&cnt)) |=> bufreg == shreg);

   p_open_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !src[1] |-> sdo_out == shreg[MSB]);

   p_latch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (src == 2'd2 && $past(src) == 2'd2 && sck_in && $past(sck_in)) |-> sdo_out == $past(sdo_out));

   p_dc_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 2'd2 && !two_wire) |-> !bus_rdata[DATA_W-4]);
endmodule

bind ssi_unit ssi_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .sck_in    (sck_in),
   .sdi_in    (sdi_in),
   .sdo_out   (sdo_out),
   .shreg     (shreg_q),
   .bufreg    (buf_q),
   .cnt       (cnt_q),
   .flag_ovf  (flag_ovf),
   .data_wr   (data_wr),
   .stat_wr   (stat_wr),
   .shift_ev  (shift_ev),
   .cnt_ev    (cnt_ev),
   .two_wire  (two_wire),
   .src       (ctrl_src)
);

// File: tb/ssi_unit_tb.sv
`timescale 1ns/1ps
module ssi_unit_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] addr = '0;
   logic       wr = 1'b0;
   logic [7:0] wdata = '0;
   logic       tmr = 1'b0, sck = 1'b0, sdi = 1'b0;
   logic       pk = 1'b0, pi = 1'b0;
   logic [7:0] rdata;
   logic       sdo;
   int n_chk = 0, n_fail = 0;

   // reference model state
   int m_sr = 0, m_buf = 0, m_cnt = 0, m_fst = 0, m_fov = 0, m_fsp = 0;
   int m_wm = 0, m_cs = 0, m_cbs = 0, m_sckq = 0, m_sdiq = 0, m_lat = 0;

   always #10 clk = ~clk;

   ssi_unit u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
      .bus_rdata(rdata), .tmr_match(tmr), .sck_in(sck), .sdi_in(sdi), .sdo_out(sdo)
   );

   function automatic int m_sdo();
      int open;
      if (m_cs < 2)       open = 1;
      else if (m_cs == 2) open = (sck == 1'b0);
      else                open = (sck == 1'b1);
      return open ? ((m_sr >> 7) & 1) : m_lat;
   endfunction

   function automatic int m_rd();
      int dc;
      dc = (m_wm >= 2) && (((m_sr >> 7) & 1) != int'(sdi));
      case (addr)
         2'd0:    return m_sr;
         2'd1:    return m_buf;
         2'd2:    return (m_fst << 7) | (m_fov << 6) | (m_fsp << 5) | (dc << 4) | m_cnt;
         default: return (m_wm << 4) | (m_cs << 2) | (m_cbs << 1);
      endcase
   endfunction

   task automatic m_step();
      int wd, ws, wc, stb, rise, fall, sh, ce, nsr, ovs, sst, ssp, lat_n;
      wd = wr && addr == 2'd0;
      ws = wr && addr == 2'd2;
      wc = wr && addr == 2'd3;
      stb = wc && wdata[0];
      rise = sck && !m_sckq;
      fall = !sck && m_sckq;
      case (m_cs)
         0: sh = stb;
         1: sh = int'(tmr);
         2: sh = rise;
         default: sh = fall;
      endcase
      if (m_cs < 2) ce = sh;
      else ce = m_cbs ? stb : (rise || fall);
      nsr = wd ? int'(wdata) : (sh ? (((m_sr << 1) | int'(sdi)) & 255) : m_sr);
      ovs = !ws && ce && m_cnt == 15;
      if (m_wm >= 2) begin
         sst = sck && m_sckq && m_sdiq && !sdi;
         ssp = sck && m_sckq && !m_sdiq && sdi;
      end else begin
         sst = (m_cs >= 2) && !m_cbs && (rise || fall);
         ssp = 0;
      end
      lat_n = m_sdo();
      if (ws) m_cnt = int'(wdata[3:0]);
      else if (ce) m_cnt = (m_cnt + 1) & 15;
      if (ovs) m_buf = nsr;
      m_sr = nsr;
      m_fst = sst ? 1 : ((ws && wdata[7]) ? 0 : m_fst);
      m_fov = ovs ? 1 : ((ws && wdata[6]) ? 0 : m_fov);
      m_fsp = ssp ? 1 : ((ws && wdata[5]) ? 0 : m_fsp);
      if (wc) begin
         m_wm = int'(wdata[5:4]);
         m_cs = int'(wdata[3:2]);
         m_cbs = int'(wdata[1]);
      end
      m_sckq = int'(sck);
      m_sdiq = int'(sdi);
      m_lat = lat_n;
   endtask

   task automatic check(input string tag);
      n_chk++;
      if (rdata !== 8'(m_rd()) || sdo !== 1'(m_sdo())) begin
         n_fail++;
         $display("FAIL %s: addr=%0d rdata=%02h sdo=%0b expected rdata=%02h sdo=%0b",
                  tag, addr, rdata, sdo, 8'(m_rd()), 1'(m_sdo()));
      end
   endtask

   task automatic cyc(input string tag, input logic [1:0] a, input logic w,
                      input logic [7:0] d, input logic t);
      addr = a; wr = w; wdata = d; sck = pk; sdi = pi; tmr = t;
      #1;
      check(tag);
      @(posedge clk);
      m_step();
      @(negedge clk);
   endtask

   task automatic wr_reg(input string tag, input logic [1:0] a, input logic [7:0] d);
      cyc(tag, a, 1'b1, d, 1'b0);
   endtask

   task automatic rd_reg(input string tag, input logic [1:0] a);
      cyc(tag, a, 1'b0, 8'h00, 1'b0);
   endtask

   task automatic pin(input string tag, input logic k, input logic i, input logic [1:0] a);
      pk = k; pi = i;
      cyc(tag, a, 1'b0, 8'h00, 1'b0);
   endtask

   function automatic logic [7:0] ctl(input int wm, input int cs, input int cbs, input int stb);
      return 8'((wm << 4) | (cs << 2) | (cbs << 1) | stb);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: R1 run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] pat;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd_reg("R1", 2'd0); rd_reg("R1", 2'd1); rd_reg("R1", 2'd2); rd_reg("R1", 2'd3);
      // R2 register map
      wr_reg("R2", 2'd0, 8'hA5); rd_reg("R2", 2'd0);
      wr_reg("R2", 2'd3, ctl(1, 1, 1, 0)); rd_reg("R2", 2'd3);
      wr_reg("R2", 2'd3, ctl(0, 0, 0, 0)); rd_reg("R2", 2'd1);
      // R3 software strobe shifts, 16 strobes wrap counter (R7, R8)
      wr_reg("R3", 2'd0, 8'h00);
      pat = 8'b1011_0010;
      for (int b = 7; b >= 0; b--) begin
         pi = pat[b];
         wr_reg("R3", 2'd3, ctl(0, 0, 0, 1));
         rd_reg("R3", 2'd0);
      end
      pat = 8'b0110_1101;
      for (int b = 7; b >= 0; b--) begin
         pi = pat[b];
         wr_reg("R7", 2'd3, ctl(0, 0, 0, 1));
         rd_reg("R7", 2'd2);
      end
      rd_reg("R8", 2'd1); rd_reg("R8", 2'd0);
      // R9 clear overflow by writing one
      wr_reg("R9", 2'd2, 8'h40); rd_reg("R9", 2'd2);
      // R7 counter load then wrap with second buffer capture
      wr_reg("R7", 2'd2, 8'h0E); rd_reg("R7", 2'd2);
      pi = 1'b1;
      wr_reg("R7", 2'd3, ctl(0, 0, 0, 1)); rd_reg("R7", 2'd2);
      wr_reg("R7", 2'd3, ctl(0, 0, 0, 1)); rd_reg("R7", 2'd2); rd_reg("R8", 2'd1);
      // R10 internal source: output follows MSB at once
      wr_reg("R10", 2'd0, 8'h00); rd_reg("R10", 2'd0);
      wr_reg("R10", 2'd0, 8'h80); rd_reg("R10", 2'd0);
      // R4 timer source; strobe ignored
      wr_reg("R4", 2'd3, ctl(0, 1, 0, 0));
      wr_reg("R4", 2'd0, 8'h00);
      pi = 1'b1;
      for (int n = 0; n < 3; n++) cyc("R4", 2'd0, 1'b0, 8'h00, 1'b1);
      wr_reg("R4", 2'd3, ctl(0, 1, 0, 1)); rd_reg("R4", 2'd0);
      // R6 data write collides with timer shift
      rd_reg("R6", 2'd2);
      cyc("R6", 2'd0, 1'b1, 8'h3C, 1'b1);
      rd_reg("R6", 2'd0); rd_reg("R6", 2'd2);
      // R5 external rising edge source
      wr_reg("R5", 2'd3, ctl(1, 2, 0, 0));
      wr_reg("R5", 2'd0, 8'h00);
      pat = 8'b1101_0000;
      for (int b = 7; b >= 4; b--) begin
         pin("R5", 1'b0, pat[b], 2'd0);
         pin("R5", 1'b1, pat[b], 2'd0);
      end
      pin("R5", 1'b0, 1'b0, 2'd2);
      // R5 external falling edge source
      wr_reg("R5", 2'd3, ctl(1, 3, 0, 0));
      for (int b = 0; b < 3; b++) begin
         pin("R5", 1'b1, 1'b1, 2'd0);
         pin("R5", 1'b0, 1'b1, 2'd0);
      end
      // R10 latch with external rising source
      wr_reg("R10", 2'd3, ctl(0, 2, 0, 0));
      pin("R10", 1'b1, 1'b0, 2'd0);
      wr_reg("R10", 2'd0, 8'h00); rd_reg("R10", 2'd0);
      wr_reg("R10", 2'd0, 8'h80); rd_reg("R10", 2'd0);
      pin("R10", 1'b0, 1'b0, 2'd0); rd_reg("R10", 2'd0);
      // R12 edge-start in non two-wire mode
      wr_reg("R12", 2'd2, 8'hE0); rd_reg("R12", 2'd2);
      pin("R12", 1'b1, 1'b0, 2'd2); rd_reg("R12", 2'd2);
      wr_reg("R12", 2'd3, ctl(1, 2, 1, 0));
      wr_reg("R12", 2'd2, 8'hE0);
      pin("R12", 1'b0, 1'b0, 2'd2); pin("R12", 1'b1, 1'b0, 2'd2);
      wr_reg("R12", 2'd3, ctl(1, 2, 1, 1)); rd_reg("R12", 2'd2);
      // R11 two-wire start and stop conditions
      wr_reg("R11", 2'd3, ctl(2, 0, 0, 0));
      wr_reg("R11", 2'd2, 8'hE0);
      pin("R11", 1'b1, 1'b1, 2'd2); pin("R11", 1'b1, 1'b1, 2'd2);
      pin("R11", 1'b1, 1'b0, 2'd2); rd_reg("R11", 2'd2);
      pin("R11", 1'b1, 1'b1, 2'd2); rd_reg("R11", 2'd2);
      // R9 set wins over clear in same cycle
      wr_reg("R9", 2'd2, 8'hE0); rd_reg("R9", 2'd2);
      pi = 1'b0;
      wr_reg("R9", 2'd2, 8'h80); rd_reg("R9", 2'd2);
      // R13 collision status bit
      pin("R13", 1'b0, 1'b0, 2'd2);
      wr_reg("R13", 2'd0, 8'h80); rd_reg("R13", 2'd2);
      pin("R13", 1'b0, 1'b1, 2'd2);
      wr_reg("R13", 2'd3, ctl(1, 0, 0, 0));
      pin("R13", 1'b0, 1'b0, 2'd2); rd_reg("R13", 2'd2);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule